// File: doc/BRIEF.md
# Clock Source Mode Controller

This block tracks which oscillator clocks the CPU of a small microcontroller and which oscillators are kept running. Software writes register-style control bits for the main oscillator stop, the main clock select, the subsystem select and the internal oscillator stop. The controller reacts only when one of these bits changes. It accepts the change when the move is legal from the current operating status, and it rejects it otherwise. It drives the oscillator enables, a CPU clock-select code, a watchdog clock enable and a numbered status code.

Some moves need a qualifier. Switching the CPU to the main oscillator needs a stabilization-done flag, seen since the last reset or STOP release. Moving from the main clock to the subsystem clock needs the main-clock status input to read 1. Stopping the main oscillator needs that input to read 0. The CPU can never move directly between the subsystem clock and the internal oscillator.

HALT and STOP requests park the block in a low-power status. An interrupt brings it back to the status it left. A strap input can force the watchdog clock off while the block is in low power. A rejected request raises a one-cycle error pulse and leaves the status unchanged. Any reset source returns the block to its reset status.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset the block is in status 2. The status code reads 2, clk_sel reads 0, main_osc_en, int_osc_en and wdt_clk_en are 1, and err is 0.
  - A high on any bit of rst_src at a clock edge restores this state synchronously. rst_n restores it asynchronously.
- R2: A rising main_sel in status 2 moves the block to status 3 (CPU on the main clock).
  - This happens only when osc_stable has been seen high, at an earlier edge, since the last reset, STOP entry or main oscillator restart. Otherwise the request is rejected.
- R3: A rising sub_sel in status 3 moves the block to status 4 (CPU on the subsystem clock) only when main_stat is 1. Otherwise the request is rejected.
  - A falling sub_sel in status 4 returns the block to status 3.
  - A falling main_sel in status 3 returns the block to status 2.
- R4: A rising main_stop in status 2 moves the block to status 1, where main_osc_en is 0. This happens only when main_stat is 0; otherwise the request is rejected.
  - A falling main_stop in status 1 returns the block to status 2 and clears the stabilization flag.
- R5: Any change of sub_sel in status 1 or 2 is rejected, and so is any change of main_sel in status 4 or 5. There is no direct move between internal and subsystem operation.
- R6: A rising int_stop in status 4 moves the block to status 5, where int_osc_en is 0. A falling int_stop in status 5 returns the block to status 4.
- R7: A high halt_req in statuses 1 to 5 enters status 6 (HALT). A high stop_req enters status 7 (STOP).
  - stop_req wins when both are high, and both win over a control-bit change in the same cycle. That change is then dropped without an error.
  - A high irq in status 6 or 7 returns the block to the status it left.
  - In STOP, main_osc_en is 0 and the stabilization flag is cleared.
  - Control-bit changes made while in status 6 or 7 are dropped.
- R8: wdt_clk_en follows int_osc_en. It is forced to 0 in status 6 or 7 while strap_int_swstop is 1.
- R9: A control-bit change that the table in R2 to R6 does not list, or more than one control bit changing in the same cycle, is rejected. A rejected request leaves the status unchanged and sets err high for exactly the following cycle.
- R10: The clk_sel code is 0 for the internal oscillator (statuses 1, 2), 1 for the main clock (status 3) and 2 for the subsystem clock (statuses 4, 5). In statuses 6 and 7 it holds the code of the status that was left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_src | input | NUM_RST | Synchronous reset sources (pin, power-on, low voltage, clock monitor, watchdog) |
| main_stop | input | 1 | Main oscillator stop control bit |
| main_sel | input | 1 | CPU source select: internal (0) or main (1) |
| main_stat | input | 1 | Main-clock status bit |
| sub_sel | input | 1 | CPU subsystem-clock select bit |
| int_stop | input | 1 | Internal oscillator stop bit (subsystem operation) |
| osc_stable | input | 1 | Main oscillator stabilization done |
| halt_req | input | 1 | HALT request |
| stop_req | input | 1 | STOP request |
| irq | input | 1 | Interrupt, releases HALT or STOP |
| strap_int_swstop | input | 1 | Strap: software may stop the internal oscillator |
| main_osc_en | output | 1 | Main oscillator enable |
| int_osc_en | output | 1 | Internal oscillator enable |
| clk_sel | output | 2 | CPU clock source code |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| status | output | 3 | Current status code 1..7 |
| err | output | 1 | One-cycle rejected-request pulse |

## Verification
The bench targets the stabilization gate after reset, after the main oscillator is restarted and after STOP release. A design that kept a stale flag would switch to the main clock too early. Every forbidden edge is applied in each status, including a direct move between internal and subsystem operation and two bits changing at once. A design that got these wrong would move the status code or fail to raise the one-cycle error pulse. Low-power entry is checked with the strap both set and clear, and with HALT and STOP requested together. This exposes a watchdog enable that stays on, a wrong return status after the interrupt, or control edges that leak through the low-power state. A seeded random phase then compares every output against a reference model on every cycle.

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl #(
  parameter int NUM_RST = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_RST-1:0] rst_src,
  input  logic               main_stop,
  input  logic               main_sel,
  input  logic               main_stat,
  input  logic               sub_sel,
  input  logic               int_stop,
  input  logic               osc_stable,
  input  logic               halt_req,
  input  logic               stop_req,
  input  logic               irq,
  input  logic               strap_int_swstop,
  output logic               main_osc_en,
  output logic               int_osc_en,
  output logic [1:0]         clk_sel,
  output logic               wdt_clk_en,
  output logic [2:0]         status,
  output logic               err
);
  localparam logic [2:0] ST_INT_ONLY  = 3'd1;
  localparam logic [2:0] ST_INT_MAIN  = 3'd2;
  localparam logic [2:0] ST_MAIN      = 3'd3;
  localparam logic [2:0] ST_SUB       = 3'd4;
  localparam logic [2:0] ST_SUB_NOINT = 3'd5;
  localparam logic [2:0] ST_HALT      = 3'd6;
  localparam logic [2:0] ST_STOP      = 3'd7;

  logic [2:0] st, st_n, ret, ret_n;
  logic       stab, stab_clr, err_q, err_n;
  logic [3:0] prev, ctl, chg, rise, fall;
  logic       multi, run, main_on, rst_any;
  logic [2:0] eff;

  assign ctl     = {int_stop, sub_sel, main_sel, main_stop};
  assign chg     = ctl ^ prev;
  assign rise    = chg & ctl;
  assign fall    = chg & ~ctl;
  assign multi   = (chg & (chg - 4'd1)) != 4'd0;
  assign run     = (st != ST_HALT) && (st != ST_STOP);
  assign eff     = run ? st : ret;
  assign rst_any = |rst_src;
  assign main_on = (st != ST_STOP) && (eff != ST_INT_ONLY);

  always_comb begin
    st_n     = st;
    ret_n    = ret;
    err_n    = 1'b0;
    stab_clr = 1'b0;
    if (!run) begin
      if (irq) st_n = ret;
    end else if (stop_req) begin
      st_n     = ST_STOP;
      ret_n    = st;
      stab_clr = 1'b1;
    end else if (halt_req) begin
      st_n  = ST_HALT;
      ret_n = st;
    end else if (chg != 4'd0) begin
      err_n = 1'b1;
      if (!multi) begin
        unique case (st)
          ST_INT_ONLY:
            if (fall[0]) begin st_n = ST_INT_MAIN; stab_clr = 1'b1; err_n = 1'b0; end
          ST_INT_MAIN:
            if (rise[0] && !main_stat) begin st_n = ST_INT_ONLY; err_n = 1'b0; end
            else if (rise[1] && stab) begin st_n = ST_MAIN; err_n = 1'b0; end
          ST_MAIN:
            if (fall[1]) begin st_n = ST_INT_MAIN; err_n = 1'b0; end
            else if (rise[2] && main_stat) begin st_n = ST_SUB; err_n = 1'b0; end
          ST_SUB:
            if (fall[2]) begin st_n = ST_MAIN; err_n = 1'b0; end
            else if (rise[3]) begin st_n = ST_SUB_NOINT; err_n = 1'b0; end
          ST_SUB_NOINT:
            if (fall[3]) begin st_n = ST_SUB; err_n = 1'b0; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_INT_MAIN;
      ret   <= ST_INT_MAIN;
      stab  <= 1'b0;
      prev  <= 4'd0;
      err_q <= 1'b0;
    end else if (rst_any) begin
      st    <= ST_INT_MAIN;
      ret   <= ST_INT_MAIN;
      stab  <= 1'b0;
      prev  <= 4'd0;
      err_q <= 1'b0;
    end else begin
      st    <= st_n;
      ret   <= ret_n;
      prev  <= ctl;
      err_q <= err_n;
      if (stab_clr)                stab <= 1'b0;
      else if (osc_stable && main_on) stab <= 1'b1;
    end
  end

  assign status      = st;
  assign err         = err_q;
  assign clk_sel     = (eff == ST_MAIN) ? 2'd1 : (eff >= ST_SUB) ? 2'd2 : 2'd0;
  assign main_osc_en = main_on;
  assign int_osc_en  = (eff != ST_SUB_NOINT);
  assign wdt_clk_en  = int_osc_en && !(strap_int_swstop && !run);

  // R9
  err_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> status == $past(status));
  // R5
  no_int_to_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_INT_ONLY || st == ST_INT_MAIN) |=> !(st == ST_SUB || st == ST_SUB_NOINT));
  // R2
  stab_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_INT_MAIN && !stab) |=> st != ST_MAIN);
  // R3
  sub_needs_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MAIN && !main_stat) |=> st != ST_SUB);
  // R4
  main_stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_INT_MAIN && main_stat) |=> st != ST_INT_ONLY);
endmodule

// File: tb/clk_mode_ctrl_test.sv
module clk_mode_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NR-1:0] rst_src = '0;
  logic main_stop = 0, main_sel = 0, main_stat = 0, sub_sel = 0, int_stop = 0;
  logic osc_stable = 0, halt_req = 0, stop_req = 0, irq = 0, strap = 0;
  logic main_osc_en, int_osc_en, wdt_clk_en, err;
  logic [1:0] clk_sel;
  logic [2:0] status;

  int checks = 0, errors = 0;

  logic [2:0] m_st = 3'd2, m_ret = 3'd2;
  logic       m_stab = 0, m_err = 0;
  logic [3:0] m_prev = 4'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_mode_ctrl #(.NUM_RST(NR)) uut (
    .clk(clk), .rst_n(rst_n), .rst_src(rst_src), .main_stop(main_stop),
    .main_sel(main_sel), .main_stat(main_stat), .sub_sel(sub_sel),
    .int_stop(int_stop), .osc_stable(osc_stable), .halt_req(halt_req),
    .stop_req(stop_req), .irq(irq), .strap_int_swstop(strap),
    .main_osc_en(main_osc_en), .int_osc_en(int_osc_en), .clk_sel(clk_sel),
    .wdt_clk_en(wdt_clk_en), .status(status), .err(err));

  function automatic logic [2:0] f_eff();
    return (m_st >= 3'd6) ? m_ret : m_st;
  endfunction
  function automatic logic [1:0] f_sel();
    logic [2:0] e = f_eff();
    return (e == 3'd3) ? 2'd1 : (e >= 3'd4) ? 2'd2 : 2'd0;
  endfunction
  function automatic logic f_main();
    return (m_st != 3'd7) && (f_eff() != 3'd1);
  endfunction
  function automatic logic f_int();
    return f_eff() != 3'd5;
  endfunction
  function automatic logic f_wdt();
    return f_int() && !(strap && m_st >= 3'd6);
  endfunction

  task automatic model_step();
    logic [3:0] c, a;
    logic [2:0] n;
    logic e, clr, mon;
    if (!rst_n || (|rst_src)) begin
      m_st = 3'd2; m_ret = 3'd2; m_stab = 0; m_prev = 0; m_err = 0;
      return;
    end
    c = {int_stop, sub_sel, main_sel, main_stop};
    a = c ^ m_prev;
    n = m_st; e = 0; clr = 0; mon = f_main();
    if (m_st >= 3'd6) begin
      if (irq) n = m_ret;
    end else if (stop_req) begin
      n = 3'd7; m_ret = m_st; clr = 1;
    end else if (halt_req) begin
      n = 3'd6; m_ret = m_st;
    end else if (a != 0) begin
      e = 1;
      if ($countones(a) == 1) begin
        case (m_st)
          3'd1: if (a[0] && !c[0]) begin n = 3'd2; clr = 1; e = 0; end
          3'd2: if (a[0] && c[0] && !main_stat) begin n = 3'd1; e = 0; end
                else if (a[1] && c[1] && m_stab) begin n = 3'd3; e = 0; end
          3'd3: if (a[1] && !c[1]) begin n = 3'd2; e = 0; end
                else if (a[2] && c[2] && main_stat) begin n = 3'd4; e = 0; end
          3'd4: if (a[2] && !c[2]) begin n = 3'd3; e = 0; end
                else if (a[3] && c[3]) begin n = 3'd5; e = 0; end
          3'd5: if (a[3] && !c[3]) begin n = 3'd4; e = 0; end
          default: ;
        endcase
      end
    end
    if (clr) m_stab = 0;
    else if (osc_stable && mon) m_stab = 1;
    m_st = n; m_err = e; m_prev = c;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R10 status", status, m_st);
    chk("R10 clk_sel", clk_sel, f_sel());
    chk("R4 main_osc_en", main_osc_en, f_main());
    chk("R6 int_osc_en", int_osc_en, f_int());
    chk("R8 wdt_clk_en", wdt_clk_en, f_wdt());
    chk("R9 err", err, m_err);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    halt_req = 0; stop_req = 0; irq = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 status", status, 2); chk("R1 clk_sel", clk_sel, 0);
    chk("R1 main_en", main_osc_en, 1); chk("R1 int_en", int_osc_en, 1);
    chk("R1 wdt", wdt_clk_en, 1); chk("R1 err", err, 0);
    // R2 switch refused without stabilization
    main_sel = 1; cyc(); chk("R2 status", status, 2); chk("R2 err", err, 1);
    main_sel = 0; cyc(); chk("R9 err", err, 1);
    cyc(); chk("R9 pulse width", err, 0);
    osc_stable = 1; cyc(); osc_stable = 0;
    main_sel = 1; cyc(); chk("R2 status", status, 3); chk("R10 clk_sel main", clk_sel, 1);
    // R3 subsystem entry gated by main_stat
    sub_sel = 1; cyc(); chk("R3 status", status, 3); chk("R3 err", err, 1);
    sub_sel = 0; cyc();
    main_stat = 1; sub_sel = 1; cyc(); chk("R3 status", status, 4); chk("R10 clk_sel sub", clk_sel, 2);
    // R6 internal oscillator stop in subsystem mode
    int_stop = 1; cyc(); chk("R6 status", status, 5); chk("R6 int_en", int_osc_en, 0); chk("R8 wdt", wdt_clk_en, 0);
    int_stop = 0; cyc(); chk("R6 status", status, 4);
    // R5 no direct subsystem-internal move
    main_sel = 0; cyc(); chk("R5 status", status, 4); chk("R5 err", err, 1);
    main_sel = 1; cyc();
    sub_sel = 0; cyc(); chk("R3 back", status, 3);
    main_sel = 0; cyc(); chk("R3 back int", status, 2);
    sub_sel = 1; cyc(); chk("R5 status", status, 2); chk("R5 err", err, 1);
    sub_sel = 0; cyc();
    // R4 main oscillator stop
    main_stat = 1; main_stop = 1; cyc(); chk("R4 status", status, 2); chk("R4 err", err, 1);
    main_stop = 0; cyc();
    main_stat = 0; main_stop = 1; cyc(); chk("R4 status", status, 1); chk("R4 main_en", main_osc_en, 0);
    osc_stable = 1; cyc(); chk("R4 stays", status, 1);
    osc_stable = 0; main_stop = 0; cyc(); chk("R4 restart", status, 2);
    main_sel = 1; cyc(); chk("R4 stab cleared", status, 2); chk("R4 err", err, 1);
    main_sel = 0; cyc();
    // R9 simultaneous edges
    osc_stable = 1; cyc(); osc_stable = 0;
    main_sel = 1; sub_sel = 1; cyc(); chk("R9 multi status", status, 2); chk("R9 multi err", err, 1);
    main_sel = 0; sub_sel = 0; cyc();
    main_sel = 1; cyc(); chk("R2 status", status, 3);
    // R7 / R8 low power
    strap = 1; halt_req = 1; cyc(); chk("R7 halt", status, 6); chk("R10 halt sel", clk_sel, 1);
    chk("R8 wdt off", wdt_clk_en, 0); chk("R7 main_en", main_osc_en, 1);
    irq = 1; cyc(); chk("R7 return", status, 3);
    strap = 0; halt_req = 1; cyc(); chk("R8 wdt on", wdt_clk_en, 1);
    irq = 1; cyc();
    stop_req = 1; halt_req = 1; cyc(); chk("R7 stop prio", status, 7); chk("R7 stop main", main_osc_en, 0);
    sub_sel = 1; cyc(); chk("R7 ignored", status, 7); chk("R7 no err", err, 0);
    irq = 1; cyc(); chk("R7 stop return", status, 3);
    sub_sel = 0; cyc(); chk("R7 lost edge", err, 1);
    main_sel = 0; cyc(); chk("R3 to int", status, 2);
    main_sel = 1; cyc(); chk("R7 stab cleared", status, 2);
    main_sel = 0; cyc();
    // R1 each reset source
    for (int i = 0; i < NR; i++) begin
      osc_stable = 1; cyc(); osc_stable = 0;
      main_sel = 1; cyc(); main_sel = 0; cyc();
      main_sel = 1; cyc();
      rst_src = NR'(1) << i; main_sel = 0; cyc(); rst_src = '0;
      chk("R1 src reset", status, 2); chk("R1 src err", err, 0);
    end
    // random phase
    void'($urandom(32'h5eed_c10c));
    for (int k = 0; k < 20000; k++) begin
      int r = int'($urandom_range(0, 99));
      main_stat  = $urandom_range(0, 1) == 1;
      osc_stable = $urandom_range(0, 2) == 0;
      if (k % 997 == 0) strap = ~strap;
      if (r < 22) begin
        case ($urandom_range(0, 3))
          0: main_stop = ~main_stop;
          1: main_sel  = ~main_sel;
          2: sub_sel   = ~sub_sel;
          default: int_stop = ~int_stop;
        endcase
      end else if (r < 25) begin
        main_sel = ~main_sel; sub_sel = ~sub_sel;
      end else if (r < 28) halt_req = 1;
      else if (r < 30) stop_req = 1;
      else if (r < 45) irq = 1;
      else if (r == 99 && $urandom_range(0, 9) == 0) rst_src = NR'(1) << $urandom_range(0, NR - 1);
      cyc();
      rst_src = '0;
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule